// File: doc/BRIEF.md
# Memory Test Access Port

This block is the boundary-scan test port of a synchronous memory die. A 16-state controller steers the scan path from the TMS input. It holds a 3-bit instruction register and three data registers behind it: a 1-bit bypass stage, a 32-bit identification word and a 70-cell boundary chain (length set by a parameter). The chain copies the parallel pin-sample vector at capture time. One instruction also raises a request that puts the memory's data pins in high impedance while the pins are sampled. Memory contents never reach the scan path, and the boundary register never drives pins. Pad pull-ups outside the block make a floating TMS or TDI read as 1. A floating TMS therefore walks the controller into its reset state.

The controller has no test-reset pin. It starts in the reset state when the power-on reset `por_n` is low, and it can also be reset by clocking TMS high. The state transitions are given as (TMS=1 / TMS=0):
- RESET → RESET / IDLE
- IDLE → DR_SELECT / IDLE
- DR_SELECT → IR_SELECT / DR_CAPTURE
- DR_CAPTURE → DR_EXIT1 / DR_SHIFT
- DR_SHIFT → DR_EXIT1 / DR_SHIFT
- DR_EXIT1 → DR_UPDATE / DR_PAUSE
- DR_PAUSE → DR_EXIT2 / DR_PAUSE
- DR_EXIT2 → DR_UPDATE / DR_SHIFT
- DR_UPDATE → DR_SELECT / IDLE
- IR_SELECT → RESET / IR_CAPTURE

The IR_CAPTURE, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2 and IR_UPDATE states mirror their DR counterparts.

Registers shift from TDI toward TDO, least significant bit first. Inputs are sampled on the rising TCK edge. TDO and its enable change on the falling edge.

Top module: `scan_tap_port`

## Requirements
- R1: While `por_n` is low, the controller is in RESET, `tdo_oe` is 0 and `dq_hiz_req` is 0. After `por_n` is released, the active instruction is IDCODE (001), so the first data scan returns the identification word.
- R2: Five consecutive rising TCK edges with TMS=1 bring the controller to RESET from any of the 16 states. One more edge in RESET reloads IDCODE and clears any high-impedance request.
- R3: IR_CAPTURE loads 001 into the instruction shift stage, so an instruction scan shifts out 1, 0, 0. The code shifted in becomes active at the edge that leaves IR_UPDATE.
- R4: Under IDCODE (001), a data scan returns a 32-bit word with these fields: bit 0 = 1; bits 11:1 = 00001001110; bits 17:12 = vendor field (default 000000); bits 27:18 = configuration field (default 0011000100); bits 31:28 = revision (default 0000). After 32 bits, TDI data follows.
- R5: Codes 011, 101, 110 and 111 select the 1-bit bypass stage. It captures 0, and TDI appears on TDO one shift later.
- R6: Codes 000 and 100 select the boundary chain. DR_CAPTURE copies `pin_sample`, and cell i is shifted out as the i-th bit. After BSR_LEN bits, TDI data follows. `dq_hiz_req` stays 0 under these codes.
- R7: Code 010 selects the boundary chain like R6 and holds `dq_hiz_req` at 1. The request starts at the update of that code and ends at the update of any other code or on entering RESET. Data scans do not change it.
- R8: `tdo_oe` is 1 exactly while the controller is in DR_SHIFT or IR_SHIFT. It changes on the falling TCK edge.
- R9: A scan may pass through DR_EXIT1, DR_PAUSE and DR_EXIT2 and re-enter DR_SHIFT without losing or repeating a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| pin_sample | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| dq_hiz_req | output | 1 | Request to float the memory data pins |

## Verification
Each shift bit is due on TDO at the falling edge after the rising edge that moved the controller into, or kept it in, a shift state. The bench drives TMS and TDI just after a falling edge and samples TDO and `tdo_oe` one time unit after the next falling edge. This way, every bit is read in the half cycle where it is valid.

An instruction takes effect at the rising edge that leaves IR_UPDATE. The high-impedance request is therefore checked one step after that state. A captured value is checked as the first bit out, and each later bit one step after the previous one.

The bench sweeps all eight codes, a walking one across all 70 boundary cells, and a TMS-reset from each of the 16 states. Expected values come from the capture length and capture value of each register.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SELECT,
        ST_DR_CAPTURE,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPDATE,
        ST_IR_SELECT,
        ST_IR_CAPTURE,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPDATE
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_BOUNDARY
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST     = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE     = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_HIZ = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS     = 3'b011;
    localparam logic [IR_W-1:0] OP_SAMPLE     = 3'b100;
    localparam logic [IR_W-1:0] OP_SPARE      = 3'b101;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;
    localparam logic [10:0]     MFR_CODE       = 11'b00001001110;

    function automatic dr_sel_e dr_select(input logic [IR_W-1:0] code);
        dr_sel_e s;
        unique case (code)
            OP_IDCODE:                          s = DR_IDENT;
            OP_EXTEST, OP_SAMPLE_HIZ, OP_SAMPLE: s = DR_BOUNDARY;
            default:                            s = DR_BYPASS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:      state_d = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       state_d = tms ? ST_DR_SELECT : ST_IDLE;
            ST_DR_SELECT:  state_d = tms ? ST_IR_SELECT : ST_DR_CAPTURE;
            ST_DR_CAPTURE: state_d = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   state_d = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   state_d = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   state_d = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   state_d = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  state_d = tms ? ST_DR_SELECT : ST_IDLE;
            ST_IR_SELECT:  state_d = tms ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: state_d = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   state_d = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   state_d = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   state_d = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   state_d = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  state_d = tms ? ST_DR_SELECT : ST_IDLE;
            default:       state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        in_reset = 1'b0;
        cap_dr   = 1'b0;
        sh_dr    = 1'b0;
        cap_ir   = 1'b0;
        sh_ir    = 1'b0;
        upd_ir   = 1'b0;
        unique case (state_q)
            ST_RESET:      in_reset = 1'b1;
            ST_DR_CAPTURE: cap_dr   = 1'b1;
            ST_DR_SHIFT:   sh_dr    = 1'b1;
            ST_IR_CAPTURE: cap_ir   = 1'b1;
            ST_IR_SHIFT:   sh_ir    = 1'b1;
            ST_IR_UPDATE:  upd_ir   = 1'b1;
            default:       ;
        endcase
    end

    // R2: five TMS-high edges always end in RESET
    p_tms_reset_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |-> ##0 1'b1 ##1 (state_q == ST_RESET));

    // R9: pause holds the controller out of shift until EXIT2
    p_pause_exit_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_DR_PAUSE && !tms) |=> (state_q == ST_DR_PAUSE));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_sh <= '0;
        end else if (cap_ir) begin
            ir_sh <= IR_CAPTURE_PAT;
        end else if (sh_ir) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)        ir_q <= OP_IDCODE;
        else if (in_reset) ir_q <= OP_IDCODE;
        else if (upd_ir)   ir_q <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];

    // R3: capture stage holds the fixed pattern one edge after IR_CAPTURE
    p_capture_pat_r3: assert property (@(posedge tck) disable iff (!rst_n)
        cap_ir |=> (ir_sh == IR_CAPTURE_PAT));

    // R7: the active instruction only moves at an update or in reset
    p_ir_change_r7: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(ir_q) |-> ($past(upd_ir) || $past(in_reset)));

    // R1: reset state always leaves IDCODE active
    p_reset_idcode_r1: assert property (@(posedge tck) disable iff (!rst_n)
        in_reset |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 70,
    parameter logic [31:0] ID_WORD = 32'h0000_009D
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  logic               cap_dr,
    input  logic               sh_dr,
    input  logic [IR_W-1:0]    ir_code,
    input  logic [BSR_LEN-1:0] pin_sample,
    output logic               dr_lsb
);

    localparam int ID_W = 32;

    dr_sel_e            sel;
    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic [BSR_LEN-1:0] bsr_d;
    logic               byp_en;
    logic               id_en;
    logic               bsr_en;

    assign sel    = dr_select(ir_code);
    assign byp_en = (sel == DR_BYPASS)   && (cap_dr || sh_dr);
    assign id_en  = (sel == DR_IDENT)    && (cap_dr || sh_dr);
    assign bsr_en = (sel == DR_BOUNDARY) && (cap_dr || sh_dr);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)      byp_q <= 1'b0;
        else if (byp_en) byp_q <= cap_dr ? 1'b0 : tdi;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)     id_q <= '0;
        else if (id_en) id_q <= cap_dr ? ID_WORD : {tdi, id_q[ID_W-1:1]};
    end

    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        if (i == BSR_LEN - 1) begin : g_head
            assign bsr_d[i] = cap_dr ? pin_sample[i] : tdi;
        end else begin : g_body
            assign bsr_d[i] = cap_dr ? pin_sample[i] : bsr_q[i+1];
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)      bsr_q <= '0;
        else if (bsr_en) bsr_q <= bsr_d;
    end

    always_comb begin
        unique case (sel)
            DR_IDENT:    dr_lsb = id_q[0];
            DR_BOUNDARY: dr_lsb = bsr_q[0];
            default:     dr_lsb = byp_q;
        endcase
    end

    // R5: bypass stage captures zero
    p_bypass_zero_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && sel == DR_BYPASS) |=> (byp_q == 1'b0));

    // R4: fixed identification fields after capture
    p_id_fields_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && sel == DR_IDENT) |=> (id_q[0] && id_q[11:1] == MFR_CODE));

    // R6: boundary chain copies the pin vector present at capture
    p_pin_capture_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && sel == DR_BOUNDARY) |=> (bsr_q == $past(pin_sample)));

    // R9: outside capture and shift the data registers keep their bits
    p_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (!cap_dr && !sh_dr) |=> ($stable(bsr_q) && $stable(id_q) && $stable(byp_q)));

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 70,
    parameter logic [3:0]  ID_REV  = 4'b0000,
    parameter logic [9:0]  ID_CFG  = 10'b0011000100,
    parameter logic [5:0]  ID_VEND = 6'b000000
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [BSR_LEN-1:0] pin_sample,
    output logic               dq_hiz_req
);

    localparam logic [31:0] ID_WORD = {ID_REV, ID_CFG, ID_VEND, MFR_CODE, 1'b1};

    tap_state_e      state_q;
    logic            in_reset;
    logic            cap_dr;
    logic            sh_dr;
    logic            cap_ir;
    logic            sh_ir;
    logic            upd_ir;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck      (tck),
        .rst_n    (por_n),
        .tms      (tms),
        .state_q  (state_q),
        .in_reset (in_reset),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir)
    );

    tap_ir u_ir (
        .tck      (tck),
        .rst_n    (por_n),
        .tdi      (tdi),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .ir_q     (ir_q),
        .ir_lsb   (ir_lsb)
    );

    tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck        (tck),
        .rst_n      (por_n),
        .tdi        (tdi),
        .cap_dr     (cap_dr),
        .sh_dr      (sh_dr),
        .ir_code    (ir_q),
        .pin_sample (pin_sample),
        .dr_lsb     (dr_lsb)
    );

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= sh_dr || sh_ir;
            if (sh_ir)      tdo <= ir_lsb;
            else if (sh_dr) tdo <= dr_lsb;
        end
    end

    assign dq_hiz_req = (ir_q == OP_SAMPLE_HIZ);

    // R8: output enable window matches the shift states
    p_oe_window_r8: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == (state_q == ST_DR_SHIFT || state_q == ST_IR_SHIFT));

    // R7: a high-impedance request never shows in RESET's successor edge
    p_hiz_cleared_r7: assert property (@(posedge tck) disable iff (!por_n)
        in_reset |=> !dq_hiz_req);

endmodule

// File: tb/test_scan_tap_port.sv
module test_scan_tap_port;

    localparam int TCK_PERIOD = 20;
    localparam int BSR_N      = 70;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] EXP_ID = {4'b0000, 10'b0011000100, 6'b000000, 11'b00001001110, 1'b1};

    localparam int          PLEN [16] = '{0, 3, 1, 2, 3, 3, 4, 5, 4, 2, 3, 4, 4, 5, 6, 5};
    localparam logic [7:0]  PBITS[16] = '{8'd0, 8'd7, 8'd1, 8'd1, 8'd1, 8'd5, 8'd5, 8'd21,
                                          8'd13, 8'd3, 8'd3, 8'd3, 8'd11, 8'd11, 8'd43, 8'd27};

    logic             tck = 1'b0;
    logic             por_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b1;
    logic             tdo;
    logic             tdo_oe;
    logic [BSR_N-1:0] pin_sample = '0;
    logic             dq_hiz_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int oe_bad = 0;

    scan_tap_port i_scan_tap_port (
        .tck        (tck),
        .por_n      (por_n),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .pin_sample (pin_sample),
        .dq_hiz_req (dq_hiz_req)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge tck) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cyc, WATCHDOG);
            report();
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic q);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
        q = tdo;
    endtask

    task automatic step_shift(input logic m, input logic d, output logic q);
        step(m, d, q);
        if (!m && tdo_oe !== 1'b1) oe_bad++;
    endtask

    // From IDLE: load an instruction, return captured bits, end in IDLE.
    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        logic q;
        cap = '0;
        step(1, 1, q);
        step(1, 1, q);
        step(0, 1, q);
        step_shift(0, 1, q);
        cap[0] = q;
        for (int i = 0; i < 3; i++) begin
            step_shift(i == 2, code[i], q);
            if (i < 2) cap[i+1] = q;
        end
        step(1, 1, q);
        step(0, 1, q);
    endtask

    // From IDLE: scan n bits, optional pause after bit index pause_at.
    task automatic scan_dr(input int n, input logic [127:0] din, input int pause_at,
                           output logic [127:0] dout);
        logic q;
        dout = '0;
        step(1, 1, q);
        step(0, 1, q);
        step_shift(0, 1, q);
        dout[0] = q;
        for (int i = 0; i < n; i++) begin
            if (i == pause_at && i < n - 1) begin
                step(1, din[i], q);
                step(0, 1, q);
                step(0, 1, q);
                step(1, 1, q);
                step_shift(0, 1, q);
                dout[i+1] = q;
            end else begin
                step_shift(i == n - 1, din[i], q);
                if (i < n - 1) dout[i+1] = q;
            end
        end
        step(1, 1, q);
        step(0, 1, q);
    endtask

    function automatic logic [127:0] expect_scan(input int len, input logic [127:0] cap,
                                                 input logic [127:0] din, input int n);
        logic [127:0] r = '0;
        for (int i = 0; i < n; i++)
            r[i] = (i < len) ? cap[i] : din[i-len];
        return r;
    endfunction

    initial begin
        logic [2:0]   ircap;
        logic [127:0] dout;
        logic [127:0] pat;
        logic         q;
        int           len;
        logic [127:0] capv;

        pat = 128'h5A3C_96E1_0FF0_C3A5_7E81_2D4B_B4D2_1E87;
        pin_sample = {6'b101101, 64'hC3A5_0F1E_9D2B_7741};

        repeat (3) @(negedge tck);
        #1;
        // R1: reset outputs
        check("R1 tdo_oe in reset", {127'b0, tdo_oe}, 128'd0);
        check("R1 dq_hiz_req in reset", {127'b0, dq_hiz_req}, 128'd0);
        por_n = 1'b1;
        step(0, 1, q);
        scan_dr(40, pat, -1, dout);
        check("R1 IDCODE active after power-up", dout, expect_scan(32, {96'b0, EXP_ID}, pat, 40));
        check("R8 tdo_oe low in IDLE", {127'b0, tdo_oe}, 128'd0);

        // Sweep of all instruction codes: R3..R7
        for (int c = 0; c < 8; c++) begin
            scan_ir(c[2:0], ircap);
            check("R3 captured IR pattern", {125'b0, ircap}, 128'd1);
            check("R7 dq_hiz_req after update", {127'b0, dq_hiz_req}, {127'b0, c == 2});
            if (c == 1) begin
                len = 32; capv = {96'b0, EXP_ID};
            end else if (c == 0 || c == 2 || c == 4) begin
                len = BSR_N; capv = {58'b0, pin_sample};
            end else begin
                len = 1; capv = '0;
            end
            scan_dr(100, pat, -1, dout);
            if (c == 1)      check("R4 identification word", dout, expect_scan(len, capv, pat, 100));
            else if (c == 2) check("R7 boundary under SAMPLE-HIZ", dout, expect_scan(len, capv, pat, 100));
            else if (len == BSR_N) check("R6 boundary capture", dout, expect_scan(len, capv, pat, 100));
            else check("R5 bypass delay", dout, expect_scan(len, capv, pat, 100));
            check("R7 dq_hiz_req kept through data scan", {127'b0, dq_hiz_req}, {127'b0, c == 2});
            pat = {pat[126:0], pat[127] ^ pat[100]};
        end

        // R6: walking one over every boundary cell
        scan_ir(3'b100, ircap);
        for (int b = 0; b < BSR_N; b++) begin
            pin_sample = '0;
            pin_sample[b] = 1'b1;
            scan_dr(BSR_N, pat, -1, dout);
            check("R6 walking-one cell", dout, expect_scan(BSR_N, {58'b0, pin_sample}, pat, BSR_N));
        end

        // R9: pause in the middle of a boundary scan
        pin_sample = {6'b010011, 64'h1234_5678_9ABC_DEF0};
        for (int p = 0; p < 3; p++) begin
            scan_dr(100, pat, 10 + p * 29, dout);
            check("R9 pause keeps bit order", dout, expect_scan(BSR_N, {58'b0, pin_sample}, pat, 100));
        end

        // R7: request cleared by entering RESET
        scan_ir(3'b010, ircap);
        check("R7 request raised", {127'b0, dq_hiz_req}, 128'd1);
        for (int k = 0; k < 5; k++) step(1, 1, q);
        step(0, 1, q);
        check("R7 request cleared by reset", {127'b0, dq_hiz_req}, 128'd0);

        // R2: TMS reset from each of the 16 states
        for (int s = 0; s < 16; s++) begin
            scan_ir(3'b011, ircap);
            for (int k = 0; k < PLEN[s]; k++) step(PBITS[s][k], 1, q);
            for (int k = 0; k < 5; k++) step(1, 1, q);
            step(0, 1, q);
            scan_dr(40, pat, -1, dout);
            check($sformatf("R2 reset from state %0d", s), dout,
                  expect_scan(32, {96'b0, EXP_ID}, pat, 40));
        end

        // R8: enable seen in every shift sample, low outside
        check("R8 tdo_oe high during all shifts", oe_bad, 128'd0);
        check("R8 tdo_oe low in IDLE", {127'b0, tdo_oe}, 128'd0);

        report();
    end

endmodule